// File: doc/BRIEF.md
# Four-Way Cache Directory with Byte-Granular Write Tracking

This block is the tag directory of a small software-visible cache that sits between a processing core's local buffer and a 32-bit global address space. Each lookup splits the global address into a line tag, a set index and a byte offset. It compares the tag against all four ways of the indexed set in parallel. On a hit it returns the matching local buffer address in the next cycle. On a miss it stalls further lookups and picks a victim. It then runs an optional write-back followed by a line fetch over a DMA request port, installs the new tag, and answers.

Several writers may share the same global lines. For that case the directory can keep a write mask with one bit per byte for every resident line. Eviction and flush then write back only the bytes the local agent actually stored. A mode input selects between this byte-tracking behaviour and a single-writer behaviour in which every evicted line is pushed back whole. A flush request walks every resident line and writes back what the current mode calls modified.

Top module: `cache_dir_bytemask`

## Requirements
- R1: After reset every way is invalid, `req_ready` is 1 and `resp_valid`, `flush_done` and `dma_req` are 0, so the first access to any address misses without a write-back.
- R2: When the tag `req_addr[31:7]` matches a valid way of set `req_addr[7+SET_W-1:7]`, the cycle after acceptance shows `resp_valid`=1 and `resp_hit`=1. `resp_laddr` is then {way, set, byte offset}, and no DMA request is made.
- R3: On a miss the block issues at most one write-back and then exactly one fetch. After the fetch is acknowledged it answers with `resp_valid`=1, `resp_hit`=0 and the local address of the filled way.
- R4: The victim is the lowest-numbered invalid way of the set. When all ways are valid it is the way named by a per-set rotating pointer, which starts at way 0 and advances by one after each replacement of a valid line.
- R5: With `mode_multi`=1, each accepted store sets bit `offset` of the line's byte mask. A write-back drives that mask on `dma_be`, with bit i standing for byte i of the line. A valid victim whose mask is empty is replaced without a write-back.
- R6: With `mode_multi`=0, stores set no mask bits, and every valid victim is written back with all `dma_be` bits set.
- R7: A flush visits lines in set-major order with the way as the inner index. With `mode_multi`=1 it writes back each valid line with a non-empty mask. With `mode_multi`=0 it writes back every valid line in full. It clears the masks, leaves lines valid, and ends with a one-cycle `flush_done` pulse.
- R8: `dma_req` and its address, local address, direction and byte-enable fields hold steady until `dma_ack`. `dma_len` is the line size (128), `dma_write` is 1 for write-backs and 0 for fetches, and a fetch enables all bytes.
- R9: `req_ready` is 0 from the acceptance of a miss or a flush until the cycle its response or `flush_done` is shown. `flush_req` takes priority over a lookup in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_multi | input | 1 | 1: track written bytes per line; 0: whole-line write-back |
| req_valid | input | 1 | Lookup request |
| req_write | input | 1 | Request is a store |
| req_addr | input | 32 | Global byte address |
| req_ready | output | 1 | Directory idle and able to accept a lookup |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Response came from a resident line |
| resp_laddr | output | WAY_W+SET_W+7 | Local buffer byte address {way, set, offset} |
| flush_req | input | 1 | Start a flush of modified data |
| flush_done | output | 1 | One-cycle end-of-flush strobe |
| dma_req | output | 1 | DMA transfer request |
| dma_write | output | 1 | 1: local to global write-back; 0: fetch |
| dma_gaddr | output | 32 | Line-aligned global address |
| dma_laddr | output | WAY_W+SET_W+7 | Line-aligned local buffer address |
| dma_len | output | 8 | Transfer length in bytes |
| dma_be | output | 128 | Per-byte enable for the transfer |
| dma_ack | input | 1 | DMA engine accepted the request |

## Verification
The bench builds the directory with four sets instead of 128, keeping four ways and 128-byte lines. Every set therefore fills after four misses, and the rotating pointer wraps within a short run. A full flush walk covers only sixteen slots, so both its visiting order and its end pulse are observed in full. Keeping the real line size leaves the 128-bit byte masks, the line-base addresses and the 7-bit offsets at their production widths. The reference model is a behavioural one: a per-set array of tags, masks and pointers plus a queue of expected DMA transfers.

// File: rtl/cdir_pkg.sv
package cdir_pkg;

  // Directory sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL,
    ST_FL_SCAN,
    ST_FL_WB
  } cdir_state_e;

endpackage

// File: rtl/cdir_tag_match.sv
// Parallel tag compare over all ways of one set.
module cdir_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 25,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] way_tags,
  input  logic [WAYS-1:0]            way_vld,
  input  logic [TAG_W-1:0]           probe_tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);

  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = way_vld[w] && (way_tags[w] == probe_tag);
  end

  assign hit = |eq;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w]) hit_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/cdir_victim_pick.sv
// Victim choice: lowest invalid way, else the rotating pointer.
module cdir_victim_pick #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  way_vld,
  input  logic [WAY_W-1:0] rr_ptr,
  output logic [WAY_W-1:0] vic_way,
  output logic             vic_was_valid
);

  always_comb begin
    vic_way       = rr_ptr;
    vic_was_valid = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_vld[w]) begin
        vic_way       = WAY_W'(w);
        vic_was_valid = 1'b0;
      end
    end
  end

endmodule

// File: rtl/cache_dir_bytemask.sv
module cache_dir_bytemask
  import cdir_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 128,
  parameter int LINE_BYTES = 128,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int SET_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int TAG_W   = ADDR_W - OFF_W,
  localparam int LADDR_W = WAY_W + SET_W + OFF_W,
  localparam int LEN_W   = $clog2(LINE_BYTES) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_multi,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  output logic                  req_ready,
  output logic                  resp_valid,
  output logic                  resp_hit,
  output logic [LADDR_W-1:0]    resp_laddr,
  input  logic                  flush_req,
  output logic                  flush_done,
  output logic                  dma_req,
  output logic                  dma_write,
  output logic [ADDR_W-1:0]     dma_gaddr,
  output logic [LADDR_W-1:0]    dma_laddr,
  output logic [LEN_W-1:0]      dma_len,
  output logic [LINE_BYTES-1:0] dma_be,
  input  logic                  dma_ack
);

  // ---------------- address arithmetic ----------------
  function automatic logic [SET_W-1:0] set_of(logic [ADDR_W-1:0] a);
    return a[OFF_W +: SET_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] off_of(logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] base_of(logic [TAG_W-1:0] t);
    return {t, {OFF_W{1'b0}}};
  endfunction

  function automatic logic [LADDR_W-1:0] laddr_of(logic [WAY_W-1:0] w,
                                                  logic [SET_W-1:0] s,
                                                  logic [OFF_W-1:0] o);
    return {w, s, o};
  endfunction

  function automatic logic need_wb(logic v, logic [LINE_BYTES-1:0] m, logic multi);
    return v && (multi ? (|m) : 1'b1);
  endfunction

  // ---------------- directory storage ----------------
  logic [TAG_W-1:0]      tag_q   [SETS][WAYS];
  logic [LINE_BYTES-1:0] dmask_q [SETS][WAYS];
  logic [WAYS-1:0]       vld_q   [SETS];
  logic [WAY_W-1:0]      rr_q    [SETS];

  cdir_state_e            state_q;
  logic [ADDR_W-1:0]      cur_addr_q;
  logic                   cur_write_q;
  logic [WAY_W-1:0]       cur_way_q;
  logic [SET_W+WAY_W-1:0] fl_idx_q;

  logic [SET_W-1:0] cur_set;
  logic [TAG_W-1:0] cur_tag;
  logic [OFF_W-1:0] cur_off;
  assign cur_set = set_of(cur_addr_q);
  assign cur_tag = tag_of(cur_addr_q);
  assign cur_off = off_of(cur_addr_q);

  logic [SET_W-1:0] fl_set;
  logic [WAY_W-1:0] fl_way;
  logic             fl_last;
  assign fl_set  = fl_idx_q[SET_W+WAY_W-1:WAY_W];
  assign fl_way  = fl_idx_q[WAY_W-1:0];
  assign fl_last = &fl_idx_q;

  // ---------------- lookup ----------------
  logic [SET_W-1:0]              lk_set;
  logic [WAYS-1:0][TAG_W-1:0]    lk_tags;
  logic [WAYS-1:0]               lk_vld;
  logic                          lk_hit;
  logic [WAY_W-1:0]              lk_way;
  logic                          lk_all_valid;
  logic [WAY_W-1:0]              vic_way;
  logic                          vic_was_valid;

  assign lk_set       = set_of(req_addr);
  assign lk_vld       = vld_q[lk_set];
  assign lk_all_valid = &lk_vld;

  always_comb begin
    for (int w = 0; w < WAYS; w++) lk_tags[w] = tag_q[lk_set][w];
  end

  cdir_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .way_tags (lk_tags),
    .way_vld  (lk_vld),
    .probe_tag(tag_of(req_addr)),
    .hit      (lk_hit),
    .hit_way  (lk_way)
  );

  cdir_victim_pick #(.WAYS(WAYS)) u_victim (
    .way_vld      (lk_vld),
    .rr_ptr       (rr_q[lk_set]),
    .vic_way      (vic_way),
    .vic_was_valid(vic_was_valid)
  );

  // ---------------- named events ----------------
  logic ev_accept, ev_hit, ev_miss, ev_flush_start, ev_fill_done, fl_line_wb;

  assign req_ready      = (state_q == ST_IDLE) && !flush_req;
  assign ev_flush_start = (state_q == ST_IDLE) && flush_req;
  assign ev_accept      = req_ready && req_valid;
  assign ev_hit         = ev_accept && lk_hit;
  assign ev_miss        = ev_accept && !lk_hit;
  assign ev_fill_done   = (state_q == ST_FILL) && dma_ack;
  assign fl_line_wb     = need_wb(vld_q[fl_set][fl_way], dmask_q[fl_set][fl_way], mode_multi);

  // ---------------- DMA request drive ----------------
  assign dma_len = LEN_W'(LINE_BYTES);

  always_comb begin
    dma_req   = 1'b0;
    dma_write = 1'b0;
    dma_gaddr = '0;
    dma_laddr = '0;
    dma_be    = '0;
    unique case (state_q)
      ST_WB: begin
        dma_req   = 1'b1;
        dma_write = 1'b1;
        dma_gaddr = base_of(tag_q[cur_set][cur_way_q]);
        dma_laddr = laddr_of(cur_way_q, cur_set, '0);
        dma_be    = mode_multi ? dmask_q[cur_set][cur_way_q] : '1;
      end
      ST_FILL: begin
        dma_req   = 1'b1;
        dma_gaddr = base_of(cur_tag);
        dma_laddr = laddr_of(cur_way_q, cur_set, '0);
        dma_be    = '1;
      end
      ST_FL_WB: begin
        dma_req   = 1'b1;
        dma_write = 1'b1;
        dma_gaddr = base_of(tag_q[fl_set][fl_way]);
        dma_laddr = laddr_of(fl_way, fl_set, '0);
        dma_be    = mode_multi ? dmask_q[fl_set][fl_way] : '1;
      end
      default: ;
    endcase
  end

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      resp_valid  <= 1'b0;
      resp_hit    <= 1'b0;
      resp_laddr  <= '0;
      flush_done  <= 1'b0;
      cur_addr_q  <= '0;
      cur_write_q <= 1'b0;
      cur_way_q   <= '0;
      fl_idx_q    <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
        for (int w = 0; w < WAYS; w++) dmask_q[s][w] <= '0;
      end
    end else begin
      resp_valid <= 1'b0;
      flush_done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (ev_flush_start) begin
            fl_idx_q <= '0;
            state_q  <= ST_FL_SCAN;
          end else if (ev_hit) begin
            resp_valid <= 1'b1;
            resp_hit   <= 1'b1;
            resp_laddr <= laddr_of(lk_way, lk_set, off_of(req_addr));
            if (req_write && mode_multi)
              dmask_q[lk_set][lk_way][off_of(req_addr)] <= 1'b1;
          end else if (ev_miss) begin
            cur_addr_q  <= req_addr;
            cur_write_q <= req_write;
            cur_way_q   <= vic_way;
            if (vic_was_valid) rr_q[lk_set] <= rr_q[lk_set] + 1'b1;
            state_q <= need_wb(vic_was_valid, dmask_q[lk_set][vic_way], mode_multi)
                       ? ST_WB : ST_FILL;
          end
        end
        ST_WB: begin
          if (dma_ack) state_q <= ST_FILL;
        end
        ST_FILL: begin
          if (dma_ack) begin
            tag_q[cur_set][cur_way_q]   <= cur_tag;
            vld_q[cur_set][cur_way_q]   <= 1'b1;
            dmask_q[cur_set][cur_way_q] <= '0;
            if (cur_write_q && mode_multi)
              dmask_q[cur_set][cur_way_q][cur_off] <= 1'b1;
            resp_valid <= 1'b1;
            resp_hit   <= 1'b0;
            resp_laddr <= laddr_of(cur_way_q, cur_set, cur_off);
            state_q    <= ST_IDLE;
          end
        end
        ST_FL_SCAN: begin
          if (fl_line_wb) begin
            state_q <= ST_FL_WB;
          end else if (fl_last) begin
            flush_done <= 1'b1;
            state_q    <= ST_IDLE;
          end else begin
            fl_idx_q <= fl_idx_q + 1'b1;
          end
        end
        ST_FL_WB: begin
          if (dma_ack) begin
            dmask_q[fl_set][fl_way] <= '0;
            if (fl_last) begin
              flush_done <= 1'b1;
              state_q    <= ST_IDLE;
            end else begin
              fl_idx_q <= fl_idx_q + 1'b1;
              state_q  <= ST_FL_SCAN;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cdir_checker.sv
module cdir_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  localparam int LEN_W = $clog2(LINE_BYTES) + 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  mode_multi,
  input logic                  req_ready,
  input logic                  resp_valid,
  input logic                  resp_hit,
  input logic                  flush_done,
  input logic                  dma_req,
  input logic                  dma_write,
  input logic                  dma_ack,
  input logic [ADDR_W-1:0]     dma_gaddr,
  input logic [LINE_BYTES-1:0] dma_be,
  input logic [LEN_W-1:0]      dma_len,
  input logic                  ev_hit,
  input logic                  ev_miss,
  input logic                  ev_fill_done,
  input logic                  lk_all_valid,
  input logic                  vic_was_valid
);

  assert_hit_answers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> resp_valid && resp_hit);

  assert_fill_answers_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_done |=> resp_valid && !resp_hit);

  assert_invalid_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss && !lk_all_valid |-> !vic_was_valid);

  assert_full_set_rotates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss && lk_all_valid |-> vic_was_valid);

  assert_wb_not_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && dma_write |-> |dma_be);

  assert_single_full_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && dma_write && !mode_multi |-> &dma_be);

  assert_flush_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);

  assert_dma_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && !dma_ack |=> dma_req && $stable(dma_gaddr) && $stable(dma_write) && $stable(dma_be));

  assert_dma_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> dma_len == LEN_W'(LINE_BYTES));

  assert_fetch_all_bytes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && !dma_write |-> &dma_be);

  assert_stall_during_dma_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> !req_ready);

  assert_resp_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid || flush_done) |-> !dma_req);

endmodule

bind cache_dir_bytemask cdir_checker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_multi   (mode_multi),
  .req_ready    (req_ready),
  .resp_valid   (resp_valid),
  .resp_hit     (resp_hit),
  .flush_done   (flush_done),
  .dma_req      (dma_req),
  .dma_write    (dma_write),
  .dma_ack      (dma_ack),
  .dma_gaddr    (dma_gaddr),
  .dma_be       (dma_be),
  .dma_len      (dma_len),
  .ev_hit       (ev_hit),
  .ev_miss      (ev_miss),
  .ev_fill_done (ev_fill_done),
  .lk_all_valid (lk_all_valid),
  .vic_was_valid(vic_was_valid)
);

// File: tb/tb_cache_dir_bytemask.sv
module tb_cache_dir_bytemask;

  localparam int SETS = 4;
  localparam int WAYS = 4;
  localparam int LB   = 128;
  localparam int LAW  = 2 + 2 + 7;

  typedef struct packed {
    logic          wr;
    logic [31:0]   ga;
    logic [LAW-1:0] la;
    logic [LB-1:0] be;
  } dma_op_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_multi = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic req_ready, resp_valid, resp_hit, flush_done;
  logic [LAW-1:0] resp_laddr;
  logic flush_req = 1'b0;
  logic dma_req, dma_write, dma_ack = 1'b0;
  logic [31:0] dma_gaddr;
  logic [LAW-1:0] dma_laddr;
  logic [7:0] dma_len;
  logic [LB-1:0] dma_be;

  always #5 clk = ~clk;

  cache_dir_bytemask #(.ADDR_W(32), .WAYS(WAYS), .SETS(SETS), .LINE_BYTES(LB)) dut (
    .clk(clk), .rst_n(rst_n), .mode_multi(mode_multi),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_laddr(resp_laddr),
    .flush_req(flush_req), .flush_done(flush_done),
    .dma_req(dma_req), .dma_write(dma_write), .dma_gaddr(dma_gaddr), .dma_laddr(dma_laddr),
    .dma_len(dma_len), .dma_be(dma_be), .dma_ack(dma_ack)
  );

  // reference model state
  logic [24:0]   m_tag  [SETS][WAYS];
  logic          m_vld  [SETS][WAYS];
  logic [LB-1:0] m_mask [SETS][WAYS];
  int            m_rr   [SETS];
  dma_op_t       exp_q[$];

  int n_checks = 0;
  int n_err = 0;
  int cyc = 0;

  task automatic check(input string rq, input string what,
                       input logic [LB-1:0] act, input logic [LB-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int t, input int s, input int o);
    return (32'(t) << 9) | (32'(s) << 7) | 32'(o);
  endfunction

  // Serve DMA, compare requests, wait for the closing strobe.
  task automatic serve(input bit want_flush, input logic exp_hit, input logic [LAW-1:0] exp_la);
    bit done = 0;
    bit pending = 0;
    int wc = 0;
    int guard = 0;
    string rq;
    while (!done && guard < 400) begin
      @(negedge clk);
      guard++;
      if (dma_ack) begin
        dma_ack = 1'b0;
        pending = 0;
      end
      if (dma_req && !pending) begin
        pending = 1;
        wc = 0;
        if (exp_q.size() == 0) begin
          check("R3", "unexpected dma_req", 1, 0);
        end else begin
          dma_op_t e = exp_q.pop_front();
          rq = want_flush ? "R7" : (e.wr ? (mode_multi ? "R5" : "R6") : "R3");
          check("R8", "dma_write", LB'(dma_write), LB'(e.wr));
          check("R8", "dma_gaddr", LB'(dma_gaddr), LB'(e.ga));
          check(rq, "dma_laddr", LB'(dma_laddr), LB'(e.la));
          check(rq, "dma_be", dma_be, e.be);
          check("R8", "dma_len", LB'(dma_len), LB'(128));
        end
      end else if (pending) begin
        wc++;
        if (wc == 2) dma_ack = 1'b1;
      end
      if (want_flush) begin
        if (flush_done) done = 1;
        else check("R9", "req_ready during flush", LB'(req_ready), 0);
        if (resp_valid) check("R7", "resp during flush", 1, 0);
      end else begin
        if (resp_valid) begin
          done = 1;
          check(exp_hit ? "R2" : "R3", "resp_hit", LB'(resp_hit), LB'(exp_hit));
          check(exp_hit ? "R2" : "R4", "resp_laddr", LB'(resp_laddr), LB'(exp_la));
        end else begin
          check("R9", "req_ready while busy", LB'(req_ready), 0);
        end
      end
    end
    if (!done) check(want_flush ? "R7" : "R3", "no closing strobe", 0, 1);
    check(want_flush ? "R7" : "R3", "missing dma ops", LB'(exp_q.size()), 0);
    dma_ack = 1'b0;
  endtask

  task automatic access(input bit wr, input logic [31:0] a);
    int s = int'(a[8:7]);
    logic [24:0] t = a[31:7];
    logic [6:0] o = a[6:0];
    bit hit = 0;
    int hw = 0;
    int vw = -1;
    logic [LAW-1:0] la;
    for (int w = 0; w < WAYS; w++)
      if (m_vld[s][w] && m_tag[s][w] == t) begin hit = 1; hw = w; end
    if (hit) begin
      if (wr && mode_multi) m_mask[s][hw][o] = 1'b1;
      la = {2'(hw), 2'(s), o};
    end else begin
      for (int w = WAYS - 1; w >= 0; w--) if (!m_vld[s][w]) vw = w;
      if (vw < 0) begin
        vw = m_rr[s];
        m_rr[s] = (m_rr[s] + 1) % WAYS;
        if (!mode_multi || m_mask[s][vw] != '0)
          exp_q.push_back('{1'b1, {m_tag[s][vw], 7'd0}, {2'(vw), 2'(s), 7'd0},
                           mode_multi ? m_mask[s][vw] : {LB{1'b1}}});
      end
      exp_q.push_back('{1'b0, {t, 7'd0}, {2'(vw), 2'(s), 7'd0}, {LB{1'b1}}});
      m_tag[s][vw] = t;
      m_vld[s][vw] = 1'b1;
      m_mask[s][vw] = '0;
      if (wr && mode_multi) m_mask[s][vw][o] = 1'b1;
      la = {2'(vw), 2'(s), o};
    end
    @(negedge clk);
    check("R9", "req_ready when idle", LB'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    @(posedge clk);
    #1 req_valid = 1'b0;
    serve(0, hit, la);
  endtask

  task automatic do_flush();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        if (m_vld[s][w] && (!mode_multi || m_mask[s][w] != '0))
          exp_q.push_back('{1'b1, {m_tag[s][w], 7'd0}, {2'(w), 2'(s), 7'd0},
                           mode_multi ? m_mask[s][w] : {LB{1'b1}}});
        m_mask[s][w] = '0;
      end
    @(negedge clk);
    flush_req = 1'b1;
    @(posedge clk);
    #1 flush_req = 1'b0;
    serve(1, 1'b0, '0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_err++;
        n_checks++;
        $display("FAIL watchdog: actual=%0d expected<150000", cyc);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
      end
    end
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < WAYS; w++) begin
        m_vld[s][w] = 0; m_mask[s][w] = '0; m_tag[s][w] = '0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    check("R1", "req_ready", LB'(req_ready), 1);
    check("R1", "resp_valid", LB'(resp_valid), 0);
    check("R1", "dma_req", LB'(dma_req), 0);
    check("R1", "flush_done", LB'(flush_done), 0);

    mode_multi = 1'b1;
    access(0, mk(1, 0, 5));     // R1/R3: cold miss, no write-back
    access(1, mk(1, 0, 5));     // R2 hit, mark byte 5
    access(1, mk(1, 0, 100));   // R5 mark byte 100
    access(1, mk(2, 0, 3));     // R4 way1
    access(0, mk(3, 0, 0));
    access(0, mk(4, 0, 127));
    access(0, mk(7, 1, 9));     // other set
    access(0, mk(5, 0, 1));     // R5 evict way0 with mask
    access(0, mk(6, 0, 2));     // evict way1, mask {3}
    access(0, mk(8, 0, 2));     // evict way2, empty mask: fetch only
    access(1, mk(4, 0, 60));    // hit way3
    do_flush();                 // R7 multi
    do_flush();                 // R7 nothing left
    mode_multi = 1'b0;
    access(1, mk(5, 0, 10));    // R6 no marking
    access(0, mk(9, 0, 0));     // R6 full write-back of way3
    do_flush();                 // R7 single: every valid line
    mode_multi = 1'b1;
    access(1, mk(7, 1, 33));
    access(0, mk(10, 1, 0));    // R4 invalid way1 first
    do_flush();                 // R7 only set1 way0
    access(0, mk(5, 0, 1));     // R2 still resident after flushes

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule